// File: doc/BRIEF.md
# Matrix Keypad Scanner with Bus Read-Out and Interrupt

This block scans a 4x4 switch-matrix keypad and hands each new keypress to a processor over a simple memory-mapped read port. A prescaler divides the bus clock into a slow scan tick. The block drives one column at a time, advances to the next column on each tick, and samples all four row lines through a two-stage synchronizer. When a sampled row is active, the block stores a 4-bit key code and raises an interrupt request.

The processor reads the keypad address to fetch the code. That read clears the interrupt. One clock later the block answers with a transfer acknowledge and a read-data enable, and it places the code on the data bus. While a code is still unread, the block drops any new press so that the code is not overwritten. A key held down produces only one interrupt. The block accepts a new press only after it has seen every row idle for a full sweep of the four columns.

Top module: `kpd_scan_top`

## Requirements
- R1: The driven column changes exactly once every DIV bus clocks. Between two changes, `col_drv` holds its value for DIV cycles.
- R2: `col_drv` is active-high and always one-hot, where bit i drives column i. After reset it is 4'b0001, and it rotates in the order column 0, 1, 2, 3, then back to 0.
- R3: The key code is {row index[1:0], column index[1:0]}, and rows are active-high. If more than one row is active in the sampled column, the lowest row index wins. On `bus_rdata` the code sits in bits 3:0, and bits DATA_W-1:4 are zero.
- R4: A sample that shows an active row, taken while no code is pending and the scanner is armed, sets `irq` and stores the code. `irq` rises only on the clock edge that ends a scan-tick cycle.
- R5: A read request is `bus_sel`=1, `bus_rd`=1 and `bus_addr`=KEY_ADDR in one cycle. Such a request clears `irq` at that clock edge. In the next cycle, `bus_ack` and `bus_oe` are 1 for exactly one cycle and `bus_rdata` holds the stored code. A read made while no code is pending returns the last stored code and leaves `irq` at 0.
- R6: The block ignores reads at any other address and requests with `bus_rd`=0: there is no acknowledge, `irq` is unchanged and `bus_rdata` stays 0. Whenever `bus_oe` is 0, `bus_rdata` is 0.
- R7: While `irq` is 1, a new press does not change the stored code, and that press is discarded.
- R8: Any sample with an active row disarms the scanner. The scanner re-arms only after four consecutive tick samples with all rows idle. A held key therefore raises only one interrupt, and a key pressed again after such a release raises a new one.
- R9: In reset `col_drv` is 4'b0001, and `irq`, `bus_ack`, `bus_oe` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronously upstream |
| row_in | input | 4 | Keypad row lines, active-high |
| col_drv | output | 4 | One-hot column drive, active-high |
| bus_sel | input | 1 | Bus transaction select |
| bus_rd | input | 1 | 1 = read transaction |
| bus_addr | input | ADDR_W | Transaction address |
| bus_rdata | output | DATA_W | Read data: the zero-extended key code |
| bus_ack | output | 1 | Transfer acknowledge for a keypad read |
| bus_oe | output | 1 | Read-data enable toward the processor |
| irq | output | 1 | Key-pending interrupt request |

## Verification
The hardest situation to reach from the ports is a second press that arrives while the first code is still unread, followed by a read that must return the first code and leave nothing pending. The bench models the keypad matrix from `col_drv` and a table of pressed switches, and it stores the first code without reading it. It then releases the key, waits through a full quiet sweep so that the scanner re-arms, and holds a different key long enough to be sampled. A held key that stays down across many sweeps after its read tests the single-interrupt rule, and the bench also checks that a re-press after release does raise a new interrupt.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int unsigned NUM_ROWS = 4;
  localparam int unsigned NUM_COLS = 4;
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS);
  localparam int unsigned COL_W    = $clog2(NUM_COLS);
  localparam int unsigned CODE_W   = ROW_W + COL_W;

  typedef logic [CODE_W-1:0] key_code_t;
endpackage

// File: rtl/kpd_prescaler.sv
module kpd_prescaler #(
  parameter int unsigned DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kpd_scanner.sv
module kpd_scanner
  import kpd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [NUM_ROWS-1:0] row_in,
  output logic [NUM_COLS-1:0] col_drv,
  output logic                press_evt,
  output key_code_t           press_code
);
  localparam int unsigned QW = $clog2(NUM_COLS) + 1;
  localparam logic [QW-1:0] Q_FULL = QW'(NUM_COLS - 1);

  logic [COL_W-1:0]    col_q, col_d;
  logic [NUM_ROWS-1:0] row_m_q, row_s_q;
  logic [QW-1:0]       quiet_q, quiet_d;
  logic                armed_q, armed_d;
  logic                hit;
  logic [ROW_W-1:0]    row_idx;

  // column decode
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_drv[c] = (col_q == COL_W'(c));
  end

  // lowest active row wins
  always_comb begin
    row_idx = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (row_s_q[r]) row_idx = ROW_W'(r);
    end
  end

  always_comb begin
    hit        = |row_s_q;
    col_d      = tick ? col_q + 1'b1 : col_q;
    quiet_d    = quiet_q;
    armed_d    = armed_q;
    if (tick) begin
      if (hit) begin
        quiet_d = '0;
        armed_d = 1'b0;
      end else if (quiet_q >= Q_FULL) begin
        armed_d = 1'b1;
      end else begin
        quiet_d = quiet_q + 1'b1;
      end
    end
    press_evt  = tick & hit & armed_q;
    press_code = {row_idx, col_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_m_q <= '0;
      row_s_q <= '0;
      quiet_q <= Q_FULL;
      armed_q <= 1'b1;
    end else begin
      col_q   <= col_d;
      row_m_q <= row_in;
      row_s_q <= row_m_q;
      quiet_q <= quiet_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/kpd_key_hold.sv
module kpd_key_hold
  import kpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      press_evt,
  input  key_code_t press_code,
  input  logic      rd_clr,
  output logic      pending,
  output key_code_t key_q
);
  logic      pend_q, pend_d;
  key_code_t key_r, key_d;
  logic      key_en;

  always_comb begin
    pend_d = pend_q;
    key_en = 1'b0;
    if (pend_q) begin
      if (rd_clr) pend_d = 1'b0;
    end else if (press_evt) begin
      pend_d = 1'b1;
      key_en = 1'b1;
    end
    key_d = key_en ? press_code : key_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      key_r  <= '0;
    end else begin
      pend_q <= pend_d;
      key_r  <= key_d;
    end
  end

  assign pending = pend_q;
  assign key_q   = key_r;
endmodule

// File: rtl/kpd_bus_if.sv
module kpd_bus_if
  import kpd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  key_code_t         key_q,
  output logic              rd_req,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_oe
);
  localparam int unsigned PAD_W = DATA_W - CODE_W;

  logic              ack_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rd_req  = bus_sel & bus_rd & (bus_addr == KEY_ADDR);
    rdata_d = rd_req ? {{PAD_W{1'b0}}, key_q} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= rd_req;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_oe    = ack_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int unsigned DIV      = 1024,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(8'h40)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        row_in,
  output logic [3:0]        col_drv,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_oe,
  output logic              irq
);
  logic      scan_tick;
  logic      press_evt;
  key_code_t press_code;
  key_code_t key_code;
  logic      rd_req;

  kpd_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (scan_tick)
  );

  kpd_scanner u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (scan_tick),
    .row_in    (row_in),
    .col_drv   (col_drv),
    .press_evt (press_evt),
    .press_code(press_code)
  );

  kpd_key_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .press_evt (press_evt),
    .press_code(press_code),
    .rd_clr    (rd_req),
    .pending   (irq),
    .key_q     (key_code)
  );

  kpd_bus_if #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_ADDR(KEY_ADDR)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .key_q    (key_code),
    .rd_req   (rd_req),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack),
    .bus_oe   (bus_oe)
  );
endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_tick,
  input logic [3:0]        col_drv,
  input logic              rd_req,
  input logic              irq,
  input logic              bus_ack,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [3:0]        key_code
);
  // R2: exactly one column driven
  assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_drv) == 1);

  // R1: column moves only after a scan tick
  assert_col_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(col_drv));

  // R4: interrupt rises only from a tick sample
  assert_irq_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scan_tick));

  // R5: a read acknowledges next cycle and clears a pending interrupt
  assert_read_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (bus_ack && bus_oe));
  assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && irq) |=> !irq);
  assert_no_spurious_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_ack);

  // R6: idle data bus is zero
  assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_rdata == '0));

  // R7: pending code is not overwritten
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> $stable(key_code));
endmodule

bind kpd_scan_top kpd_scan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_tick(scan_tick),
  .col_drv  (col_drv),
  .rd_req   (rd_req),
  .irq      (irq),
  .bus_ack  (bus_ack),
  .bus_oe   (bus_oe),
  .bus_rdata(bus_rdata),
  .key_code (key_code)
);

// File: tb/kpd_scan_top_tb.sv
module kpd_scan_top_tb;
  localparam int unsigned DIV    = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] KADDR = 4'hA;
  localparam int unsigned QUIET = 6 * DIV;

  logic              clk, rst_n;
  logic [3:0]        row_in, col_drv;
  logic              bus_sel, bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_ack, bus_oe, irq;
  logic [15:0]       pressed;   // bit r*4+c
  int                checks, fails;
  logic              finished;
  logic [DATA_W-1:0] exp_q[$];

  kpd_scan_top #(.DIV(DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_drv(col_drv),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_oe(bus_oe), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // keypad matrix model
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_in[r] = |(pressed[r*4 +: 4] & col_drv);
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected ack", 1, 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(bus_rdata == e && bus_oe, "R3/R5 read data", bus_rdata, e);
      end
    end
  end

  task automatic bus_req(input logic rd, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = rd; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic key_read(input logic [3:0] code);
    exp_q.push_back({4'b0, code});
    bus_req(1'b1, KADDR);
  endtask

  task automatic wait_irq(input string req, input logic want);
    int n = 0;
    while (irq !== want && n < QUIET) begin
      @(negedge clk);
      n++;
    end
    check(irq === want, req, irq, want);
  endtask

  task automatic press(input int r, input int c);
    pressed[r*4+c] = 1'b1;
  endtask

  task automatic release_all();
    pressed = '0;
    repeat (QUIET) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    pressed = '0; bus_sel = 0; bus_rd = 0; bus_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(col_drv == 4'b0001, "R9 col reset", col_drv, 1);
    check(!irq && !bus_ack && !bus_oe && bus_rdata == 0, "R9 outputs reset",
          {irq, bus_ack, bus_oe}, 0);
    rst_n = 1'b1;

    // R1 / R2 rotation and period
    begin
      logic [3:0] prev;
      int n;
      @(negedge clk);
      prev = col_drv;
      while (col_drv == prev) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        prev = col_drv;
        n = 0;
        while (col_drv == prev && n < 4 * DIV) begin
          @(negedge clk);
          n++;
        end
        check(n == DIV, "R1 column period", n, DIV);
        check(col_drv == {prev[2:0], prev[3]}, "R2 rotation order", col_drv,
              {prev[2:0], prev[3]});
      end
    end

    // R3 / R4 / R5 single keys
    begin
      int kr[4] = '{0, 3, 1, 2};
      int kc[4] = '{0, 3, 2, 1};
      for (int i = 0; i < 4; i++) begin
        press(kr[i], kc[i]);
        wait_irq("R4 irq on press", 1'b1);
        pressed = '0;
        key_read(4'(kr[i] * 4 + kc[i]));
        @(negedge clk);
        check(irq == 1'b0, "R5 irq cleared by read", irq, 0);
        release_all();
      end
    end

    // R3 lowest row wins
    press(2, 1); press(1, 1);
    wait_irq("R4 irq two rows", 1'b1);
    pressed = '0;
    key_read(4'h5);
    release_all();

    // R8 held key: one interrupt, then re-arm after release
    press(0, 3);
    wait_irq("R8 first irq", 1'b1);
    key_read(4'h3);
    repeat (10 * DIV) @(negedge clk);
    check(irq == 1'b0, "R8 held key no second irq", irq, 0);
    release_all();
    press(0, 3);
    wait_irq("R8 re-press irq", 1'b1);
    pressed = '0;
    key_read(4'h3);
    release_all();

    // R7 no overwrite while pending
    press(1, 0);
    wait_irq("R7 first irq", 1'b1);
    release_all();
    press(2, 2);
    repeat (QUIET) @(negedge clk);
    check(irq == 1'b1, "R7 irq still pending", irq, 1);
    release_all();
    key_read(4'h4);
    repeat (QUIET) @(negedge clk);
    check(irq == 1'b0, "R7 second press dropped", irq, 0);

    // R6 ignored requests
    press(3, 0);
    wait_irq("R6 setup irq", 1'b1);
    pressed = '0;
    bus_req(1'b1, KADDR ^ 4'h1);
    check(!bus_ack && irq && bus_rdata == 0, "R6 other address ignored",
          {bus_ack, irq}, 1);
    bus_req(1'b0, KADDR);
    check(!bus_ack && irq && bus_rdata == 0, "R6 write ignored", {bus_ack, irq}, 1);
    key_read(4'hC);
    @(negedge clk);
    check(irq == 1'b0, "R5 read clears", irq, 0);

    // R5 idle read returns last code
    key_read(4'hC);
    @(negedge clk);
    check(irq == 1'b0 && exp_q.size() == 0, "R5 idle read", irq, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads acknowledged", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule